// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Interface

This block is the bus-facing register front end of a two-channel serial controller. Each channel is reached through two byte ports only: a command port and a data port. The sixteen write registers and sixteen read registers of a channel sit behind a pointer. The first command write chooses a register and the second command write stores into it. A command read returns the chosen read register. Either way the pointer then falls back to register 0.

The data port carries traffic. A write sends the byte to the transmit side, and with local loopback on it also feeds the same byte into that channel's own receive FIFO. A read pops the oldest received byte. Receive bytes arrive from an outside source through a push port, and each channel has a small FIFO of parameterised depth.

Interrupt-pending bits for both channels are kept together in one register that can only be read through channel A. Reading it clears it. A level interrupt output is high while any pending bit is set and its enables are still on.

Top module: `serx_regif`

## Requirements
- R1: After synchronous reset, `bus_rdata` is 0x00, `irq`, `tx_valid` and both `rx_overrun` bits are low, both pointers are at register 0 in the select phase, and both receive FIFOs are empty.
- R2: The first command-port write of a channel loads the pointer from bits 3:0 of the written byte. The second stores the whole byte into the pointed write register and returns the pointer to 0 in the select phase.
- R3: A command-port read returns the read register at the pointer one cycle later on `bus_rdata`, then resets the pointer to 0 and cancels a pending select phase, so the next command write is again a select.
- R4: Byte offset bit 3 selects channel B (1) or A (0). Offset bits 2:0 equal to 1 address the command port and equal to 5 the data port. Accesses at any other offset change no state, start no transmit and leave `bus_rdata` unchanged.
- R5: Read registers 12 and 13 of a channel return the last values stored in that channel's write registers 12 and 13.
- R6: Read register 0 has bit 2 (transmit empty) always 1 and bit 0 set while the channel's receive FIFO holds data, with all other bits 0. Read register 1 and every read register not named in R5, R6 or R12 read as 0x00.
- R7: A data-port write drives `tx_valid` high for exactly the next cycle, with `tx_byte` the written byte and `tx_chan` the channel.
- R8: When bit 4 of a channel's write register 14 is 1, each data-port write also pushes the byte into that channel's own receive FIFO. When it is 0, nothing is pushed.
- R9: A data-port read returns the oldest byte of that channel's FIFO and removes it. On an empty FIFO it returns 0x00. Bytes come out in arrival order.
- R10: The master interrupt enable is bit 3 of write register 9, one register shared by both channels and written from either. When it is set and bit 1 of a channel's write register 1 is set, a data-port write on that channel sets the pending bit for that channel: bit 4 for A, bit 1 for B.
- R11: When the master enable is set and bits 4:3 of channel A's write register 1 are not both 0, a non-empty receive FIFO sets its pending bit (bit 5 for A, bit 2 for B) in the following cycle, and keeps setting it while data remains.
- R12: Read register 3 of channel A returns the pending byte and clears it. A data-port read of either channel also clears it. Read register 3 of channel B reads 0x00 and clears nothing.
- R13: `irq` is high exactly while a pending bit is set whose enables (master, plus the matching transmit enable or receive mode) are currently on. Dropping the master enable lowers `irq` within two cycles without clearing the pending byte.
- R14: A push into a full FIFO is dropped. So is an external push that collides with a loopback push to the same channel in the same cycle. Either case sets that channel's `rx_overrun` bit, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: bit 3 channel, bits 2:0 port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered, valid the cycle after a read |
| rx_in_valid | input | 1 | Push one received byte |
| rx_in_chan | input | 1 | Target channel of the push |
| rx_in_data | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_chan | output | 1 | Channel of the transmitted byte |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt request |
| rx_overrun | output | 2 | Sticky per-channel overrun flags |

## Verification
Every bus access is registered once. Read data, the transmit strobe, overrun flags, cleared pending bits and the interrupt fall all appear right after the edge that takes the access, and the bench samples them at the following falling edge. Receive-pending bits, and `irq` when it comes from them, need one more edge after a FIFO push or after a clearing read that left data behind. A change of the master enable reaches `irq` one edge after the store. The bench idles exactly those cycles before it samples. Read results are queued by the driver at issue and compared by a monitor one edge later.

// File: rtl/serx_pkg.sv
package serx_pkg;

  localparam int unsigned N_CH = 2;
  localparam int unsigned IDX_W = 4;

  // port offsets within a channel (bits 2:0 of the byte offset)
  localparam logic [2:0] OFF_CMD  = 3'd1;
  localparam logic [2:0] OFF_DATA = 3'd5;

  // register indices the block decodes
  localparam logic [IDX_W-1:0] RIDX_STAT  = 4'd0;
  localparam logic [IDX_W-1:0] RIDX_PEND  = 4'd3;
  localparam logic [IDX_W-1:0] WIDX_IEN   = 4'd1;
  localparam logic [IDX_W-1:0] WIDX_MIE   = 4'd9;
  localparam logic [IDX_W-1:0] WIDX_ECHOA = 4'd12;
  localparam logic [IDX_W-1:0] WIDX_ECHOB = 4'd13;
  localparam logic [IDX_W-1:0] WIDX_LOOP  = 4'd14;

  // bit positions inside the decoded registers
  localparam int unsigned B_TXIE  = 1;
  localparam int unsigned B_RXM   = 3;   // receive mode occupies bits 4:3
  localparam int unsigned B_MIE   = 3;
  localparam int unsigned B_LOOP  = 4;

  // pending register layout
  localparam int unsigned PEND_W  = 6;
  localparam int unsigned P_TXB   = 1;
  localparam int unsigned P_RXB   = 2;
  localparam int unsigned P_TXA   = 4;
  localparam int unsigned P_RXA   = 5;

  typedef enum logic {PH_SELECT, PH_STORE} ptr_phase_e;

endpackage

// File: rtl/serx_ptr_seq.sv
module serx_ptr_seq
  import serx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic             cmd_rd,
  input  logic [IDX_W-1:0] sel_val,
  output logic [IDX_W-1:0] ptr,
  output logic             reg_we
);

  ptr_phase_e phase_q;

  assign reg_we = cmd_wr && (phase_q == PH_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      phase_q <= PH_SELECT;
    end else if (cmd_rd) begin
      ptr     <= '0;
      phase_q <= PH_SELECT;
    end else if (cmd_wr) begin
      if (phase_q == PH_SELECT) begin
        ptr     <= sel_val;
        phase_q <= PH_STORE;
      end else begin
        ptr     <= '0;
        phase_q <= PH_SELECT;
      end
    end
  end

endmodule

// File: rtl/serx_rx_fifo.sv
module serx_rx_fifo #(
  parameter int unsigned DEPTH = 4,   // power of two, at least 2
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign dout  = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push && !full) wp_q <= wp_q + 1'b1;
      if (pop && !empty) rp_q <= rp_q + 1'b1;
    end
  end

endmodule

// File: rtl/serx_irq_ctrl.sv
module serx_irq_ctrl
  import serx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mie,
  input  logic              rx_en,
  input  logic [N_CH-1:0]   txie,
  input  logic [N_CH-1:0]   rx_avail,
  input  logic [N_CH-1:0]   tx_hit,
  input  logic              clr,
  output logic [PEND_W-1:0] pend,
  output logic              irq
);

  logic [PEND_W-1:0] set_v, mask_v, pend_nxt;

  always_comb begin
    set_v  = '0;
    mask_v = '0;
    set_v[P_TXA]  = mie && txie[0] && tx_hit[0];
    set_v[P_TXB]  = mie && txie[1] && tx_hit[1];
    set_v[P_RXA]  = mie && rx_en && rx_avail[0];
    set_v[P_RXB]  = mie && rx_en && rx_avail[1];
    mask_v[P_TXA] = mie && txie[0];
    mask_v[P_TXB] = mie && txie[1];
    mask_v[P_RXA] = mie && rx_en;
    mask_v[P_RXB] = mie && rx_en;
    pend_nxt = clr ? '0 : (pend | set_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      irq  <= |(pend_nxt & mask_v);
    end
  end

endmodule

// File: rtl/serx_regif.sv
module serx_regif
  import serx_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [3:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic            rx_in_valid,
  input  logic            rx_in_chan,
  input  logic [7:0]      rx_in_data,
  output logic            tx_valid,
  output logic            tx_chan,
  output logic [7:0]      tx_byte,
  output logic            irq,
  output logic [N_CH-1:0] rx_overrun
);

  localparam int unsigned DW = 8;

  logic            acc_ch;
  logic [2:0]      acc_off;
  logic [N_CH-1:0] cmd_wr, cmd_rd, dat_wr, dat_rd;
  logic [N_CH-1:0] reg_we, txie_q, loop_q, rx_empty, rx_full, ovr_q;
  logic [IDX_W-1:0] ptr [N_CH];
  logic [DW-1:0]   echo_a_q [N_CH];
  logic [DW-1:0]   echo_b_q [N_CH];
  logic [DW-1:0]   rx_dout  [N_CH];
  logic            mie_q;
  logic [1:0]      rxm_q;
  logic [PEND_W-1:0] pend;
  logic            pend_clr;
  logic [DW-1:0]   rr_val;

  assign acc_ch  = bus_addr[3];
  assign acc_off = bus_addr[2:0];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit, loop_push, ext_push, push;

    assign hit       = bus_sel && (acc_ch == 1'(c));
    assign cmd_wr[c] = hit && bus_we  && (acc_off == OFF_CMD);
    assign cmd_rd[c] = hit && !bus_we && (acc_off == OFF_CMD);
    assign dat_wr[c] = hit && bus_we  && (acc_off == OFF_DATA);
    assign dat_rd[c] = hit && !bus_we && (acc_off == OFF_DATA);

    serx_ptr_seq u_ptr (
      .clk    (clk),
      .rst    (rst),
      .cmd_wr (cmd_wr[c]),
      .cmd_rd (cmd_rd[c]),
      .sel_val(bus_wdata[IDX_W-1:0]),
      .ptr    (ptr[c]),
      .reg_we (reg_we[c])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        txie_q[c]   <= 1'b0;
        loop_q[c]   <= 1'b0;
        echo_a_q[c] <= '0;
        echo_b_q[c] <= '0;
      end else if (reg_we[c]) begin
        case (ptr[c])
          WIDX_IEN:   txie_q[c]   <= bus_wdata[B_TXIE];
          WIDX_LOOP:  loop_q[c]   <= bus_wdata[B_LOOP];
          WIDX_ECHOA: echo_a_q[c] <= bus_wdata;
          WIDX_ECHOB: echo_b_q[c] <= bus_wdata;
          default: ;
        endcase
      end
    end

    assign loop_push = dat_wr[c] && loop_q[c];
    assign ext_push  = rx_in_valid && (rx_in_chan == 1'(c));
    assign push      = loop_push || ext_push;

    serx_rx_fifo #(.DEPTH(RX_DEPTH), .W(DW)) u_fifo (
      .clk  (clk),
      .rst  (rst),
      .push (push),
      .din  (loop_push ? bus_wdata : rx_in_data),
      .pop  (dat_rd[c]),
      .dout (rx_dout[c]),
      .empty(rx_empty[c]),
      .full (rx_full[c])
    );

    always_ff @(posedge clk) begin
      if (rst) ovr_q[c] <= 1'b0;
      else if ((push && rx_full[c]) || (loop_push && ext_push)) ovr_q[c] <= 1'b1;
    end
  end

  // shared master enable, written from either channel; receive mode from A only
  always_ff @(posedge clk) begin
    if (rst) begin
      mie_q <= 1'b0;
      rxm_q <= '0;
    end else begin
      if ((reg_we[0] && ptr[0] == WIDX_MIE) || (reg_we[1] && ptr[1] == WIDX_MIE))
        mie_q <= bus_wdata[B_MIE];
      if (reg_we[0] && ptr[0] == WIDX_IEN)
        rxm_q <= bus_wdata[B_RXM +: 2];
    end
  end

  assign pend_clr = (cmd_rd[0] && ptr[0] == RIDX_PEND) || (|dat_rd);

  serx_irq_ctrl u_irq (
    .clk     (clk),
    .rst     (rst),
    .mie     (mie_q),
    .rx_en   (|rxm_q),
    .txie    (txie_q),
    .rx_avail(~rx_empty),
    .tx_hit  (dat_wr),
    .clr     (pend_clr),
    .pend    (pend),
    .irq     (irq)
  );

  always_comb begin
    rr_val = '0;
    case (ptr[acc_ch])
      RIDX_STAT:  rr_val = {5'b0, 1'b1, 1'b0, ~rx_empty[acc_ch]};
      RIDX_PEND:  rr_val = acc_ch ? '0 : {{(DW-PEND_W){1'b0}}, pend};
      WIDX_ECHOA: rr_val = echo_a_q[acc_ch];
      WIDX_ECHOB: rr_val = echo_b_q[acc_ch];
      default:    rr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_chan   <= 1'b0;
      tx_byte   <= '0;
    end else begin
      if (|cmd_rd)      bus_rdata <= rr_val;
      else if (|dat_rd) bus_rdata <= rx_empty[acc_ch] ? '0 : rx_dout[acc_ch];
      tx_valid <= |dat_wr;
      if (|dat_wr) begin
        tx_chan <= acc_ch;
        tx_byte <= bus_wdata;
      end
    end
  end

  assign rx_overrun = ovr_q;

endmodule

// File: rtl/serx_regif_chk.sv
module serx_regif_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel,
  input logic       bus_we,
  input logic [3:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic       tx_valid,
  input logic       irq,
  input logic [1:0] rx_overrun,
  input logic       mie,
  input logic [1:0] rx_empty
);

  logic dat_wr_now, dat_rd_now, empty_now;
  assign dat_wr_now = bus_sel && bus_we  && (bus_addr[2:0] == 3'd5);
  assign dat_rd_now = bus_sel && !bus_we && (bus_addr[2:0] == 3'd5);
  assign empty_now  = rx_empty[bus_addr[3]];

  a_r7_tx_follows_write: assert property (@(posedge clk) disable iff (rst)
    dat_wr_now |=> tx_valid);

  a_r7_no_tx_without_write: assert property (@(posedge clk) disable iff (rst)
    !dat_wr_now |=> !tx_valid);

  a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (dat_rd_now && empty_now) |=> (bus_rdata == 8'h00));

  a_r12_data_read_drops_irq: assert property (@(posedge clk) disable iff (rst)
    dat_rd_now |=> !irq);

  a_r13_irq_needs_master: assert property (@(posedge clk) disable iff (rst)
    !mie |=> !irq);

  a_r14_overrun_a_sticky: assert property (@(posedge clk) disable iff (rst)
    rx_overrun[0] |=> rx_overrun[0]);

  a_r14_overrun_b_sticky: assert property (@(posedge clk) disable iff (rst)
    rx_overrun[1] |=> rx_overrun[1]);

endmodule

bind serx_regif serx_regif_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .rx_overrun(rx_overrun),
  .mie       (mie_q),
  .rx_empty  (rx_empty)
);

// File: tb/serx_regif_tb.sv
module serx_regif_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_in_valid = 1'b0, rx_in_chan = 1'b0;
  logic [7:0] rx_in_data = '0;
  logic       tx_valid, tx_chan, irq;
  logic [7:0] tx_byte;
  logic [1:0] rx_overrun;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  localparam logic [3:0] CMD_A = 4'd1, DAT_A = 4'd5, CMD_B = 4'd9, DAT_B = 4'd13;

  always #4 clk = ~clk;

  serx_regif #(.RX_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_in_valid(rx_in_valid),
    .rx_in_chan(rx_in_chan), .rx_in_data(rx_in_data), .tx_valid(tx_valid),
    .tx_chan(tx_chan), .tx_byte(tx_byte), .irq(irq), .rx_overrun(rx_overrun)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares each issued read one edge later
  always @(posedge clk)
    rd_seen <= bus_sel && !bus_we && (bus_addr[2:0] == 3'd1 || bus_addr[2:0] == 3'd5);

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(logic [3:0] a, logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic reg_wr(logic ch, logic [3:0] idx, logic [7:0] v);
    bus_write({ch, 3'd1}, {4'h0, idx});
    bus_write({ch, 3'd1}, v);
  endtask

  task automatic reg_rd(logic ch, logic [3:0] idx, logic [7:0] e, string tag);
    bus_write({ch, 3'd1}, {4'h0, idx});
    bus_read({ch, 3'd1}, e, tag);
  endtask

  task automatic push_rx(logic ch, logic [7:0] d);
    rx_in_valid = 1'b1; rx_in_chan = ch; rx_in_data = d;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 overrun", rx_overrun, 0);
    bus_read(CMD_A, 8'h04, "R1 pointer at 0, fifo empty");
    // R6 status and zero registers
    reg_rd(0, 4'd1, 8'h00, "R6 reg1 zero");
    reg_rd(0, 4'd7, 8'h00, "R6 unlisted reg zero");
    reg_rd(1, 4'd0, 8'h04, "R6 chan B status");
    // R5 mirrors, R2 pointer sequence
    reg_wr(0, 4'd12, 8'h5A);
    reg_wr(0, 4'd13, 8'hC3);
    reg_rd(0, 4'd12, 8'h5A, "R5 mirror 12");
    reg_rd(0, 4'd13, 8'hC3, "R5 mirror 13");
    bus_write(CMD_A, 8'hFC);
    bus_write(CMD_A, 8'h66);
    bus_read(CMD_A, 8'h04, "R2 pointer back at 0");
    reg_rd(0, 4'd12, 8'h66, "R2 low nibble select");
    // R3 read cancels select phase
    bus_write(CMD_A, 8'h0D);
    bus_read(CMD_A, 8'hC3, "R3 read selected");
    bus_write(CMD_A, 8'h0C);
    bus_write(CMD_A, 8'h77);
    reg_rd(0, 4'd12, 8'h77, "R3 phase cancelled");
    // R4 channel select and ignored offsets
    reg_wr(1, 4'd12, 8'h33);
    reg_rd(0, 4'd12, 8'h77, "R4 chan A untouched");
    reg_rd(1, 4'd12, 8'h33, "R4 chan B own reg");
    bus_write(4'd2, 8'h0C);
    bus_write(4'd6, 8'h99);
    chk("R4 no tx on odd offset", tx_valid, 0);
    bus_read(CMD_A, 8'h04, "R4 odd offset left pointer");
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'd4;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R4 rdata held", bus_rdata, 8'h04);
    // R7 transmit, R8 no loopback by default
    bus_write(DAT_A, 8'hA5);
    chk("R7 tx_valid", tx_valid, 1);
    chk("R7 tx_byte", tx_byte, 8'hA5);
    chk("R7 tx_chan", tx_chan, 0);
    idle(1);
    chk("R7 one cycle", tx_valid, 0);
    bus_read(CMD_A, 8'h04, "R8 no loopback push");
    bus_read(DAT_A, 8'h00, "R9 empty read");
    // R8 loopback, R9 order
    reg_wr(0, 4'd14, 8'h10);
    bus_write(DAT_A, 8'h11);
    bus_write(DAT_A, 8'h22);
    reg_rd(0, 4'd0, 8'h05, "R8 rx avail");
    bus_read(DAT_A, 8'h11, "R9 first");
    bus_read(DAT_A, 8'h22, "R9 second");
    bus_read(DAT_A, 8'h00, "R9 drained");
    reg_wr(1, 4'd14, 8'h10);
    bus_write(DAT_B, 8'h44);
    chk("R7 tx_chan B", tx_chan, 1);
    reg_rd(0, 4'd0, 8'h04, "R8 own channel only");
    reg_rd(1, 4'd0, 8'h05, "R8 chan B avail");
    bus_read(DAT_B, 8'h44, "R8 chan B loop byte");
    reg_wr(0, 4'd14, 8'h00);
    reg_wr(1, 4'd14, 8'h00);
    // R10 transmit pending, R12 clearing
    reg_wr(0, 4'd9, 8'h08);
    reg_wr(0, 4'd1, 8'h02);
    chk("R10 no irq yet", irq, 0);
    bus_write(DAT_A, 8'h01);
    chk("R10 irq on tx A", irq, 1);
    reg_rd(0, 4'd3, 8'h10, "R10 tx A pending bit4");
    chk("R12 irq cleared", irq, 0);
    reg_rd(0, 4'd3, 8'h00, "R12 pending cleared");
    reg_wr(1, 4'd1, 8'h02);
    bus_write(DAT_B, 8'h02);
    chk("R10 irq on tx B", irq, 1);
    reg_rd(1, 4'd3, 8'h00, "R12 chan B reg3 zero");
    chk("R12 chan B read keeps irq", irq, 1);
    reg_rd(0, 4'd3, 8'h02, "R10 tx B pending bit1");
    chk("R12 irq cleared B", irq, 0);
    // R13 master enable gating, shared register 9
    bus_write(DAT_A, 8'h03);
    chk("R13 irq set", irq, 1);
    reg_wr(1, 4'd9, 8'h00);
    idle(1);
    chk("R13 irq dropped by master", irq, 0);
    reg_rd(0, 4'd3, 8'h10, "R13 pending kept");
    reg_wr(1, 4'd9, 8'h08);
    // R11 receive pending
    reg_wr(0, 4'd1, 8'h08);
    push_rx(1, 8'h5C);
    idle(1);
    chk("R11 irq on rx B", irq, 1);
    reg_rd(0, 4'd3, 8'h04, "R11 rx B pending bit2");
    chk("R12 clear on reg3 read", irq, 0);
    idle(1);
    chk("R11 re-set while data", irq, 1);
    bus_read(DAT_B, 8'h5C, "R9 rx B byte");
    chk("R12 clear on data read", irq, 0);
    idle(1);
    chk("R11 no re-set when empty", irq, 0);
    push_rx(0, 8'h6D);
    idle(1);
    reg_rd(0, 4'd3, 8'h20, "R11 rx A pending bit5");
    bus_read(DAT_A, 8'h6D, "R9 rx A byte");
    reg_wr(0, 4'd1, 8'h00);
    push_rx(0, 8'h7E);
    idle(2);
    chk("R11 mode off no irq", irq, 0);
    reg_rd(0, 4'd3, 8'h00, "R11 mode off no pending");
    reg_rd(0, 4'd0, 8'h05, "R6 rx avail bit");
    bus_read(DAT_A, 8'h7E, "R9 byte after mode off");
    // R14 overrun
    for (int i = 0; i < 5; i++) push_rx(1, 8'h81 + 8'(i));
    chk("R14 overrun B", rx_overrun, 2'b10);
    for (int i = 0; i < 4; i++) bus_read(DAT_B, 8'h81 + 8'(i), "R14 kept bytes");
    bus_read(DAT_B, 8'h00, "R14 fifth dropped");
    chk("R14 overrun sticky", rx_overrun, 2'b10);
    reg_wr(0, 4'd14, 8'h10);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = DAT_A; bus_wdata = 8'h9A;
    rx_in_valid = 1'b1; rx_in_chan = 1'b0; rx_in_data = 8'hEE;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; rx_in_valid = 1'b0;
    chk("R14 collision overrun", rx_overrun, 2'b11);
    bus_read(DAT_A, 8'h9A, "R14 loopback wins");
    bus_read(DAT_A, 8'h00, "R14 external dropped");
    idle(2);
    chk("R9 all reads compared", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule